// File: doc/BRIEF.md
# Bit-Reversed Address Increment Unit

This unit produces the next address of a bit-reversed walk, the kind used to index FFT data. It takes a current address word and a mask word. Only the low `FIELD_W` bits of the address take part in the step. The upper bits are passed straight through. Within the field, the mask selects which positions count. The carry starts at the most significant field position and moves toward bit 0. Positions the mask leaves out are treated as already full, so the carry jumps over them, and they come out as zero. When every enabled position is already one, the enabled positions wrap to zero. No carry leaves the field.

A request is a one-cycle `in_valid` strobe carrying both operands. The result is registered. `out_valid` is high for exactly one cycle, the cycle after the request. The result word then stays on `out_result` until the next request. A small control machine tracks the output:

- **ST_IDLE**: nothing has been produced since reset. Its transition is IDLE→FRESH on a request.
- **ST_FRESH**: a new result is on the output and `out_valid` is high. Its transitions are FRESH→FRESH when another request arrives and FRESH→STALE when none does.
- **ST_STALE**: the last result is held and `out_valid` is low. Its transitions are STALE→FRESH on a request and STALE→STALE otherwise.

Reset is synchronous and active high. It moves the machine to ST_IDLE from any state. `FIELD_W` must lie between 1 and `DATA_W`-1.

Top module: `brinc_unit`

## Requirements
- R1: Only the low `FIELD_W` bits (default 16) of the address take part in the increment; mask bits at positions `FIELD_W` and above have no effect on the result.
- R2: Result bits at positions `FIELD_W` and above equal the corresponding bits of the request's address.
- R3: Every field position whose mask bit is 0 yields a 0 in the result.
- R4: Over the enabled positions, the result is the address plus one with the carry entering at the highest enabled field bit and moving toward bit 0, skipping disabled positions. With mask 0x0000000F and a start address of 0, feeding each result back gives 8, 4, 12, 2, 10, 6, 14, 1, 9, 5, 13, 3, 11, 7, 15, 0.
- R5: If every enabled field position of the address is 1, all enabled positions become 0 and the upper bits are unchanged.
- R6: `out_valid` is 1 in exactly the cycle after `in_valid` was sampled high, and 0 in every other cycle.
- R7: `out_result` changes only in the cycle after a request and is otherwise held.
- R8: While reset is sampled high, `out_valid` and `out_result` are cleared, even if a request is present at the same time.
- R9: A request arriving in the cycle right after another one is served with the same one-cycle latency, and each result belongs to its own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_addr | input | DATA_W | Current address word |
| in_mask | input | DATA_W | Mask word selecting the positions that count |
| out_valid | output | 1 | High for one cycle when a new result is present |
| out_result | output | DATA_W | Next address, held between requests |

## Verification
Some rules are checked on every cycle after reset:
- R2: the upper bits are copied through.
- R3: positions the mask leaves out come out as zero.
- R5: the wrap to zero.
- R6: the one-cycle valid pulse.
- R7: the result is held between requests.

The value of the reverse-carry increment itself (R4), the effect of the mask's upper bits (R1), reset that takes precedence over a request (R8), and pairing under back-to-back traffic (R9) can only be seen in the bench's scenarios. These scenarios are the sixteen-step mask-0xF walk, a sparse mask that skips most positions, and seeded random operands compared against a reference model built from reversal.

// File: rtl/brinc_pkg.sv
package brinc_pkg;

    // Output control machine: nothing yet, new result, held result
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRESH = 2'd1,
        ST_STALE = 2'd2
    } brinc_state_e;

endpackage

// File: rtl/brinc_operand_prep.sv
module brinc_operand_prep #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 16
) (
    input  logic [DATA_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  mask_i,
    output logic [FIELD_W-1:0] sat_o,
    output logic [FIELD_W-1:0] enable_o,
    output logic [DATA_W-FIELD_W-1:0] upper_o
);
    logic [FIELD_W-1:0] addr_fld;

    always_comb begin
        addr_fld = addr_i[FIELD_W-1:0];
        enable_o = mask_i[FIELD_W-1:0];
        // disabled positions look full so the carry passes them
        sat_o    = addr_fld | ~enable_o;
        upper_o  = addr_i[DATA_W-1:FIELD_W];
    end
endmodule

// File: rtl/brinc_rev_carry.sv
module brinc_rev_carry #(
    parameter int FIELD_W = 16
) (
    input  logic [FIELD_W-1:0] sat_i,
    output logic [FIELD_W-1:0] sum_o
);
    logic [FIELD_W-1:0] carry;

    // Carry enters at the top of the field and runs toward bit 0
    assign carry[FIELD_W-1] = 1'b1;

    genvar gi;
    generate
        for (gi = FIELD_W - 2; gi >= 0; gi--) begin : g_chain
            assign carry[gi] = carry[gi+1] & sat_i[gi+1];
        end
        for (gi = 0; gi < FIELD_W; gi++) begin : g_sum
            assign sum_o[gi] = sat_i[gi] ^ carry[gi];
        end
    endgenerate

    // R5: a field that is all ones wraps fully to zero
    always_comb begin
        if (&sat_i) begin
            p_wrap_zero_r5: assert (sum_o == '0)
                else $error("R5 wrap did not clear the field");
        end
    end
endmodule

// File: rtl/brinc_merge.sv
module brinc_merge #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 16
) (
    input  logic [FIELD_W-1:0]        sum_i,
    input  logic [FIELD_W-1:0]        enable_i,
    input  logic [DATA_W-FIELD_W-1:0] upper_i,
    output logic [DATA_W-1:0]         next_o
);
    always_comb begin
        next_o = {upper_i, sum_i & enable_i};
    end
endmodule

// File: rtl/brinc_unit.sv
module brinc_unit
    import brinc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_mask,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int UPPER_W = DATA_W - FIELD_W;

    logic [FIELD_W-1:0] sat;
    logic [FIELD_W-1:0] enable;
    logic [UPPER_W-1:0] upper;
    logic [FIELD_W-1:0] sum;
    logic [DATA_W-1:0]  next_addr;
    logic [DATA_W-1:0]  result_q;

    brinc_state_e state_q, state_d;

    brinc_operand_prep #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_prep (
        .addr_i   (in_addr),
        .mask_i   (in_mask),
        .sat_o    (sat),
        .enable_o (enable),
        .upper_o  (upper)
    );

    brinc_rev_carry #(.FIELD_W(FIELD_W)) u_carry (
        .sat_i (sat),
        .sum_o (sum)
    );

    brinc_merge #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_merge (
        .sum_i    (sum),
        .enable_i (enable),
        .upper_i  (upper),
        .next_o   (next_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_FRESH : ST_IDLE;
            ST_FRESH: state_d = in_valid ? ST_FRESH : ST_STALE;
            ST_STALE: state_d = in_valid ? ST_FRESH : ST_STALE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk) begin
        if (rst)           result_q <= '0;
        else if (in_valid) result_q <= next_addr;
    end

    // outputs
    always_comb begin
        out_valid  = (state_q == ST_FRESH);
        out_result = result_q;
    end

    p_upper_keep_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_result[DATA_W-1:FIELD_W] == $past(in_addr[DATA_W-1:FIELD_W]));

    p_masked_zero_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_result[FIELD_W-1:0] & ~$past(in_mask[FIELD_W-1:0])) == '0);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

endmodule

// File: tb/brinc_unit_test.sv
`timescale 1ns/1ps
module brinc_unit_test;
    localparam int FIELD = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic [31:0] in_mask = '0;
    logic        out_valid;
    logic [31:0] out_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    brinc_unit #(.DATA_W(32), .FIELD_W(FIELD)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_addr(in_addr), .in_mask(in_mask),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [31:0] rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] m);
        logic [31:0] fm, aa, bb, d;
        fm = 32'hFFFF_FFFF >> (32 - FIELD);
        aa = a & fm;
        bb = m & fm;
        d  = rev32(rev32(aa | ~bb) + 32'd1);
        return (a & ~fm) | (d & bb);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // drive at negedge, result visible at following negedge
    task automatic issue(input logic [31:0] a, input logic [31:0] m, output logic [31:0] res);
        in_valid = 1'b1; in_addr = a; in_mask = m;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 valid", {31'd0, out_valid}, 32'd1);
        res = out_result;
    endtask

    initial begin
        logic [31:0] r, r2, a, m, cur, e;
        void'($urandom(32'd4711));
        // R8: reset wins over a simultaneous request
        in_valid = 1'b1; in_addr = 32'h1234_5678; in_mask = 32'hFFFF;
        repeat (3) @(negedge clk);
        check("R8 valid", {31'd0, out_valid}, 32'd0);
        check("R8 result", out_result, 32'd0);
        in_valid = 1'b0; rst = 1'b0;
        @(negedge clk);
        check("R6 idle", {31'd0, out_valid}, 32'd0);

        // R4 + R2: 16-step walk, mask 0xF, upper bits carried
        cur = 32'hABCD_0000;
        for (int k = 0; k < 16; k++) begin
            issue(cur, 32'h0000_000F, r);
            e = 32'hABCD_0000 | {28'd0, rev32(k + 1) [31:28]};
            check("R4 walk", r, e);
            check("R4 model", r, model(cur, 32'h0000_000F));
            cur = r;
        end
        check("R2 upper", r & 32'hFFFF_0000, 32'hABCD_0000);

        // R4: sparse mask skips the middle positions
        issue(32'h0, 32'h8001, r);       check("R4 sparse", r, 32'h8000);
        issue(32'h8000, 32'h8001, r);    check("R4 sparse", r, 32'h0001);
        issue(32'h0001, 32'h8001, r);    check("R4 sparse", r, 32'h8001);

        // R5: all enabled ones wrap, upper untouched
        issue(32'h1234_00FF, 32'h0000_00FF, r); check("R5 wrap", r, 32'h1234_0000);
        issue(32'hFFFF_FFFF, 32'h0000_FFFF, r); check("R5 wrap", r, 32'hFFFF_0000);

        // R3: disabled positions come out zero
        issue(32'h0000_FFF0, 32'h0000_0F0F, r); check("R3 zero", r & ~32'h0F0F & 32'hFFFF, 32'h0);

        // R1: upper mask bits have no effect
        issue(32'h5555_0A30, 32'h0000_00F0, r);
        issue(32'h5555_0A30, 32'hFFFF_00F0, r2);
        check("R1 mask upper", r2, r);

        // R7: held while idle, valid low
        @(negedge clk); @(negedge clk);
        check("R7 hold", out_result, r);
        check("R6 quiet", {31'd0, out_valid}, 32'd0);

        // R9: back-to-back requests
        in_valid = 1'b1; in_addr = 32'h0000_0000; in_mask = 32'h0000_00FF;
        @(negedge clk);
        check("R9 first valid", {31'd0, out_valid}, 32'd1);
        check("R9 first", out_result, model(32'h0, 32'hFF));
        in_addr = 32'h0000_0080;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 second valid", {31'd0, out_valid}, 32'd1);
        check("R9 second", out_result, model(32'h80, 32'hFF));

        // R4/R1: seeded random operands against reference
        for (int n = 0; n < 300; n++) begin
            a = $urandom; m = $urandom;
            issue(a, m, r);
            check("R4 random", r, model(a, m));
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule